// File: doc/BRIEF.md
# Serial Flash Configuration Register Unit

This block is the device-side command logic that a serial NOR flash uses to expose its configuration state over SPI mode 0. It holds three registers:

- a 16-bit persistent configuration word;
- an 8-bit runtime configuration byte;
- an 8-bit extended runtime configuration byte.

It decodes per-register read and write opcodes from the byte stream that arrives while the active-low select is held. Read data goes out on MISO, most significant bit first.

Writes are accepted only while a write-enable latch is set. A completed write clears the latch. A two-opcode software reset (arm, then execute) rebuilds the runtime bytes from the persistent word field by field. The same reset also rebuilds the 4-byte address mode flag and the extended address byte, which leave the block as plain status outputs.

The SPI pins are sampled by the system clock through synchronizer stages, so the serial clock must run at most at one sixth of the system clock. Internally, completed bytes pass from the serial front end to the decoder as a valid-only stream. The decoder always accepts a byte in the cycle it arrives, because an SPI device cannot stall its host. That same absence of back-pressure is why the block's edge has no ready signal.

Top module: `spi_cfgreg_unit`

## Requirements
- R1: After power-on reset the registers and outputs hold these values:
  - persistent word = parameter NV_INIT (default 0x8FFF);
  - runtime byte = 0x83;
  - extended byte = 0xDF;
  - write-enable latch = 0, 4-byte mode = 0, extended address = 0x00.
- R2: Opcode 0xB5 returns the persistent word in the bytes that follow it: low byte first, then high byte, each MSB first.
- R3: Opcode 0x85 returns the runtime byte and opcode 0x65 returns the extended byte, each in the single byte that follows the opcode.
- R4: The write opcodes 0xB1, 0x81 and 0x61 are ignored while the write-enable latch is clear. No data is collected and no register changes.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch also clears when a register write completes.
- R6: When enabled, opcode 0xB1 collects exactly two bytes, low byte first, into the persistent word. Opcodes 0x81 and 0x61 each collect one byte into the runtime byte and the extended byte respectively.
- R7: If select rises before all write bytes arrive, the write is discarded and the write-enable latch stays set.
- R8: Read bytes clocked beyond the register length return 0xFF, and so does the byte after an unknown opcode.
- R9: A software reset rebuilds the runtime byte from the persistent word (P) as follows:
  - bits 1:0 = 11;
  - bit 2 = 0;
  - bit 3 = 1 when P[11:9] is not 111;
  - bits 7:4 = P[15:12].
- R10: A software reset rebuilds the extended byte as follows:
  - bits 4:0 = 11111;
  - bit 5 = 0;
  - bit 6 = P[1];
  - bit 7 = P[3].
- R11: A software reset sets 4-byte mode to the inverse of P[0]. It sets the extended address to 0x03 when P[1] is 0, and to 0x00 otherwise.
- R12: The software reset executes on opcode 0x99 only if opcode 0x66 came in an earlier frame. When it executes, it clears both the write-enable latch and the armed flag. Opcode 0x99 alone has no effect.
- R13: Only the first byte after select falls is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, high while deselected |
| wr_en_latch | output | 1 | Write-enable latch state |
| addr4_mode | output | 1 | 4-byte address mode flag |
| ext_addr | output | 8 | Extended address byte |

## Verification
The bench goes after three corner cases:

- **Gated writes.** It issues each write opcode with the latch clear. A design that ignored the gate would show the written value on the next read.
- **Aborted writes.** It cuts a persistent-word write after one byte. A design that committed partial data, or that dropped the latch, would show a changed word or a cleared latch.
- **Two-step reset.** It sends 0x99 without arming and expects nothing to change. It then arms and resets with two different persistent words, so that every derived field flips at least once. A swapped bit or an inverted condition would give a wrong runtime byte, extended byte or address output.

Reads past the register length and an opcode-like value placed as the second byte of a frame must both return 0xFF.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int BYTE_W   = 8;
  localparam int NV_W     = 16;
  localparam int VR_W     = 8;
  localparam int NV_BYTES = NV_W / BYTE_W;
  localparam int IDX_W    = $clog2(NV_BYTES + 1);

  localparam logic [BYTE_W-1:0] OP_NV_RD   = 8'hB5;
  localparam logic [BYTE_W-1:0] OP_NV_WR   = 8'hB1;
  localparam logic [BYTE_W-1:0] OP_VOL_RD  = 8'h85;
  localparam logic [BYTE_W-1:0] OP_VOL_WR  = 8'h81;
  localparam logic [BYTE_W-1:0] OP_EVOL_RD = 8'h65;
  localparam logic [BYTE_W-1:0] OP_EVOL_WR = 8'h61;
  localparam logic [BYTE_W-1:0] OP_WEL_SET = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WEL_CLR = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RST_ARM = 8'h66;
  localparam logic [BYTE_W-1:0] OP_RST_GO  = 8'h99;

  typedef enum logic [1:0] {ST_OPCODE, ST_COLLECT, ST_READ, ST_SKIP} fsm_st_e;
  typedef enum logic [1:0] {TGT_NV, TGT_VOL, TGT_EVOL} tgt_e;

  // runtime byte rebuilt from the persistent word
  function automatic logic [VR_W-1:0] vol_from_nv(input logic [NV_W-1:0] nv);
    logic [VR_W-1:0] r;
    r      = '0;
    r[1:0] = 2'b11;
    r[3]   = (nv[11:9] != 3'b111);
    r[7:4] = nv[15:12];
    return r;
  endfunction

  // extended runtime byte rebuilt from the persistent word
  function automatic logic [VR_W-1:0] evol_from_nv(input logic [NV_W-1:0] nv);
    logic [VR_W-1:0] r;
    r      = '0;
    r[4:0] = 5'b11111;
    r[6]   = nv[1];
    r[7]   = nv[3];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] ext_from_nv(input logic [NV_W-1:0] nv);
    return nv[1] ? 8'h00 : 8'h03;
  endfunction
endpackage

// File: rtl/cfgreg_spi_link.sv
module cfgreg_spi_link
  import cfgreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              cs_act,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic [BYTE_W-1:0] tx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int TOP   = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sck_sr, cs_sr, mosi_sr;
  logic                   sck_d;
  logic [CNT_W-1:0]       bit_cnt;
  logic [BYTE_W-1:0]      sh_in, sh_out;
  logic                   sck_s, mosi_s, rise, fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_sr <= '0; cs_sr <= '1; mosi_sr <= '0;
        end else begin
          sck_sr <= sck; cs_sr <= cs_n; mosi_sr <= mosi;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_sr <= '0; cs_sr <= '1; mosi_sr <= '0;
        end else begin
          sck_sr  <= {sck_sr[TOP-1:0], sck};
          cs_sr   <= {cs_sr[TOP-1:0], cs_n};
          mosi_sr <= {mosi_sr[TOP-1:0], mosi};
        end
      end
    end
  endgenerate

  assign sck_s  = sck_sr[TOP];
  assign mosi_s = mosi_sr[TOP];
  assign cs_act = !cs_sr[TOP];
  assign rise   = sck_s && !sck_d;
  assign fall   = !sck_s && sck_d;
  assign miso   = cs_act ? sh_out[BYTE_W-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      bit_cnt  <= '0;
      sh_in    <= '0;
      sh_out   <= '1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      sck_d    <= sck_s;
      rx_valid <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        sh_out  <= '1;
      end else begin
        if (rise) begin
          sh_in <= {sh_in[BYTE_W-2:0], mosi_s};
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            bit_cnt  <= '0;
            rx_valid <= 1'b1;
            rx_data  <= {sh_in[BYTE_W-2:0], mosi_s};
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (fall) begin
          if (bit_cnt == '0) sh_out <= tx_byte;
          else               sh_out <= {sh_out[BYTE_W-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/cfgreg_cmd_fsm.sv
module cfgreg_cmd_fsm
  import cfgreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [NV_W-1:0]   nv_q,
  input  logic [VR_W-1:0]   vol_q,
  input  logic [VR_W-1:0]   evol_q,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              wel,
  output logic              rst_armed,
  output logic              soft_rst,
  output logic              wr_nv,
  output logic              wr_vol,
  output logic              wr_evol,
  output logic [NV_W-1:0]   wr_data_nv,
  output logic [VR_W-1:0]   wr_data_v,
  output logic              fsm_idle
);
  fsm_st_e          state;
  tgt_e             tgt;
  logic [IDX_W-1:0] cnt;
  logic [NV_W-1:0]  hold, nxt_hold;

  assign nxt_hold = {rx_data, hold[NV_W-1:BYTE_W]};
  assign fsm_idle = (state == ST_OPCODE);

  always_comb begin
    tx_byte = '1;
    if (state == ST_READ) begin
      unique case (tgt)
        TGT_NV:   if (int'(cnt) < NV_BYTES) tx_byte = nv_q[int'(cnt)*BYTE_W +: BYTE_W];
        TGT_VOL:  if (cnt == '0) tx_byte = vol_q;
        TGT_EVOL: if (cnt == '0) tx_byte = evol_q;
        default:  tx_byte = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OPCODE;
      tgt        <= TGT_NV;
      cnt        <= '0;
      hold       <= '0;
      wel        <= 1'b0;
      rst_armed  <= 1'b0;
      soft_rst   <= 1'b0;
      wr_nv      <= 1'b0;
      wr_vol     <= 1'b0;
      wr_evol    <= 1'b0;
      wr_data_nv <= '0;
      wr_data_v  <= '0;
    end else begin
      soft_rst <= 1'b0;
      wr_nv    <= 1'b0;
      wr_vol   <= 1'b0;
      wr_evol  <= 1'b0;
      if (!cs_act) begin
        state <= ST_OPCODE;
        cnt   <= '0;
      end else if (rx_valid) begin
        unique case (state)
          ST_OPCODE: begin
            cnt   <= '0;
            state <= ST_SKIP;
            case (rx_data)
              OP_NV_RD:   begin tgt <= TGT_NV;   state <= ST_READ; end
              OP_VOL_RD:  begin tgt <= TGT_VOL;  state <= ST_READ; end
              OP_EVOL_RD: begin tgt <= TGT_EVOL; state <= ST_READ; end
              OP_NV_WR:   begin tgt <= TGT_NV;   if (wel) state <= ST_COLLECT; end
              OP_VOL_WR:  begin tgt <= TGT_VOL;  if (wel) state <= ST_COLLECT; end
              OP_EVOL_WR: begin tgt <= TGT_EVOL; if (wel) state <= ST_COLLECT; end
              OP_WEL_SET: wel <= 1'b1;
              OP_WEL_CLR: wel <= 1'b0;
              OP_RST_ARM: rst_armed <= 1'b1;
              OP_RST_GO: begin
                if (rst_armed) begin
                  soft_rst  <= 1'b1;
                  wel       <= 1'b0;
                  rst_armed <= 1'b0;
                end
              end
              default: ;
            endcase
          end
          ST_COLLECT: begin
            hold <= nxt_hold;
            if (tgt == TGT_NV && cnt != IDX_W'(NV_BYTES - 1)) begin
              cnt <= cnt + 1'b1;
            end else begin
              wel        <= 1'b0;
              state      <= ST_SKIP;
              wr_data_nv <= nxt_hold;
              wr_data_v  <= rx_data;
              wr_nv      <= (tgt == TGT_NV);
              wr_vol     <= (tgt == TGT_VOL);
              wr_evol    <= (tgt == TGT_EVOL);
            end
          end
          ST_READ: if (cnt != '1) cnt <= cnt + 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
  import cfgreg_pkg::*;
#(
  parameter logic [NV_W-1:0] NV_INIT = 16'h8FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_nv,
  input  logic              wr_vol,
  input  logic              wr_evol,
  input  logic [NV_W-1:0]   wr_data_nv,
  input  logic [VR_W-1:0]   wr_data_v,
  output logic [NV_W-1:0]   nv_q,
  output logic [VR_W-1:0]   vol_q,
  output logic [VR_W-1:0]   evol_q,
  output logic              addr4,
  output logic [BYTE_W-1:0] ext_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q     <= NV_INIT;
      vol_q    <= vol_from_nv(NV_INIT);
      evol_q   <= evol_from_nv(NV_INIT);
      addr4    <= !NV_INIT[0];
      ext_addr <= ext_from_nv(NV_INIT);
    end else if (soft_rst) begin
      vol_q    <= vol_from_nv(nv_q);
      evol_q   <= evol_from_nv(nv_q);
      addr4    <= !nv_q[0];
      ext_addr <= ext_from_nv(nv_q);
    end else begin
      if (wr_nv)   nv_q   <= wr_data_nv;
      if (wr_vol)  vol_q  <= wr_data_v;
      if (wr_evol) evol_q <= wr_data_v;
    end
  end
endmodule

// File: rtl/spi_cfgreg_unit.sv
module spi_cfgreg_unit
  import cfgreg_pkg::*;
#(
  parameter logic [NV_W-1:0] NV_INIT     = 16'h8FFF,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              wr_en_latch,
  output logic              addr4_mode,
  output logic [BYTE_W-1:0] ext_addr
);
  logic              cs_act, rx_valid, wel_q, rst_armed, soft_rst, fsm_idle;
  logic              wr_nv, wr_vol, wr_evol;
  logic [BYTE_W-1:0] rx_data, tx_byte;
  logic [NV_W-1:0]   nv_q, wr_data_nv;
  logic [VR_W-1:0]   vol_q, evol_q, wr_data_v;

  cfgreg_spi_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .cs_act(cs_act), .rx_valid(rx_valid), .rx_data(rx_data), .tx_byte(tx_byte)
  );

  cfgreg_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rx_valid(rx_valid), .rx_data(rx_data),
    .nv_q(nv_q), .vol_q(vol_q), .evol_q(evol_q), .tx_byte(tx_byte), .wel(wel_q),
    .rst_armed(rst_armed), .soft_rst(soft_rst), .wr_nv(wr_nv), .wr_vol(wr_vol),
    .wr_evol(wr_evol), .wr_data_nv(wr_data_nv), .wr_data_v(wr_data_v), .fsm_idle(fsm_idle)
  );

  cfgreg_bank #(.NV_INIT(NV_INIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_nv(wr_nv), .wr_vol(wr_vol),
    .wr_evol(wr_evol), .wr_data_nv(wr_data_nv), .wr_data_v(wr_data_v), .nv_q(nv_q),
    .vol_q(vol_q), .evol_q(evol_q), .addr4(addr4_mode), .ext_addr(ext_addr)
  );

  assign wr_en_latch = wel_q;
endmodule

// File: rtl/spi_cfgreg_unit_chk.sv
module spi_cfgreg_unit_chk
  import cfgreg_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cs_act,
  input logic            fsm_idle,
  input logic            wel,
  input logic            rst_armed,
  input logic            soft_rst,
  input logic            wr_nv,
  input logic            wr_vol,
  input logic            wr_evol,
  input logic [NV_W-1:0] nv_q,
  input logic [VR_W-1:0] vol_q,
  input logic [VR_W-1:0] evol_q
);
  AST_NV_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_q != $past(nv_q)) |-> $past(wel, 2)); // R4
  AST_VOL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_q != $past(vol_q)) |-> ($past(wel, 2) || $past(soft_rst))); // R4
  AST_WEL_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_nv || wr_vol || wr_evol) |-> !wel); // R5
  AST_RESET_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!wel && !rst_armed)); // R12
  AST_RESET_VOL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (vol_q[1:0] == 2'b11 && !vol_q[2])); // R9
  AST_RESET_EVOL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (evol_q[4:0] == 5'h1F && !evol_q[5])); // R10
  AST_DESELECT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> fsm_idle); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_nv, wr_vol, wr_evol, soft_rst})); // R6
endmodule

bind spi_cfgreg_unit spi_cfgreg_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .fsm_idle(fsm_idle), .wel(wel_q),
  .rst_armed(rst_armed), .soft_rst(soft_rst), .wr_nv(wr_nv), .wr_vol(wr_vol),
  .wr_evol(wr_evol), .nv_q(nv_q), .vol_q(vol_q), .evol_q(evol_q)
);

// File: tb/spi_cfgreg_unit_tb_top.sv
module spi_cfgreg_unit_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, wel, addr4;
  logic [7:0] ext;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always #2 clk = ~clk;

  spi_cfgreg_unit dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .wr_en_latch(wel), .addr4_mode(addr4), .ext_addr(ext)
  );

  task automatic check8(input logic [7:0] act, input logic [7:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = b[i];
      repeat (H) @(negedge clk);
      sck = 1'b1;
      r[i] = miso;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] op, input int nd, input logic [7:0] d0,
                      input logic [7:0] d1, input int nrd);
    logic [7:0] r;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    spi_byte(op, r);
    if (nd > 0) spi_byte(d0, r);
    if (nd > 1) spi_byte(d1, r);
    for (int k = 0; k < nrd; k++) begin
      spi_byte(8'h00, r);
      got_q.push_back(r);
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (got_q.size() > 0) begin
        logic [7:0] g;
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL unexpected read byte actual=%02h expected=none", g);
        end else begin
          string t;
          logic [7:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check8(g, e, t);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check8({7'd0, wel}, 8'h00, "R1 wel");
    check8({7'd0, addr4}, 8'h00, "R1 addr4");
    check8(ext, 8'h00, "R1 ext");
    expect_rd(8'hFF, "R2 nv low"); expect_rd(8'h8F, "R2 nv high"); expect_rd(8'hFF, "R8 nv past end");
    xfer(8'hB5, 0, 0, 0, 3);
    expect_rd(8'h83, "R1 R3 vol"); expect_rd(8'hFF, "R8 vol past end");
    xfer(8'h85, 0, 0, 0, 2);
    expect_rd(8'hDF, "R1 R3 evol");
    xfer(8'h65, 0, 0, 0, 1);
    // R4 writes without latch
    xfer(8'h81, 1, 8'h5A, 0, 0);
    xfer(8'hB1, 2, 8'h11, 8'h22, 0);
    expect_rd(8'h83, "R4 vol unchanged");
    xfer(8'h85, 0, 0, 0, 1);
    expect_rd(8'hFF, "R4 nv lo unchanged"); expect_rd(8'h8F, "R4 nv hi unchanged");
    xfer(8'hB5, 0, 0, 0, 2);
    // R5 latch set/clear
    xfer(8'h06, 0, 0, 0, 0);
    check8({7'd0, wel}, 8'h01, "R5 set");
    xfer(8'h04, 0, 0, 0, 0);
    check8({7'd0, wel}, 8'h00, "R5 clear");
    // R6 writes
    xfer(8'h06, 0, 0, 0, 0);
    xfer(8'h81, 1, 8'h5A, 0, 0);
    check8({7'd0, wel}, 8'h00, "R5 cleared after write");
    expect_rd(8'h5A, "R6 vol write");
    xfer(8'h85, 0, 0, 0, 1);
    xfer(8'h06, 0, 0, 0, 0);
    xfer(8'h61, 1, 8'h3C, 0, 0);
    expect_rd(8'h3C, "R6 evol write");
    xfer(8'h65, 0, 0, 0, 1);
    xfer(8'h06, 0, 0, 0, 0);
    xfer(8'hB1, 2, 8'h34, 8'h12, 0);
    expect_rd(8'h34, "R6 nv low"); expect_rd(8'h12, "R6 nv high");
    xfer(8'hB5, 0, 0, 0, 2);
    // R7 aborted write
    xfer(8'h06, 0, 0, 0, 0);
    xfer(8'hB1, 1, 8'h77, 0, 0);
    check8({7'd0, wel}, 8'h01, "R7 latch kept");
    expect_rd(8'h34, "R7 nv low kept"); expect_rd(8'h12, "R7 nv high kept");
    xfer(8'hB5, 0, 0, 0, 2);
    // R12 execute without arm (latch still set)
    xfer(8'h99, 0, 0, 0, 0);
    check8({7'd0, wel}, 8'h01, "R12 unarmed keeps latch");
    expect_rd(8'h5A, "R12 unarmed vol kept");
    xfer(8'h85, 0, 0, 0, 1);
    // armed reset with nv=0x1234
    xfer(8'h66, 0, 0, 0, 0);
    xfer(8'h99, 0, 0, 0, 0);
    check8({7'd0, wel}, 8'h00, "R12 reset clears latch");
    expect_rd(8'h1B, "R9 vol from 1234");
    xfer(8'h85, 0, 0, 0, 1);
    expect_rd(8'h1F, "R10 evol from 1234");
    xfer(8'h65, 0, 0, 0, 1);
    check8({7'd0, addr4}, 8'h01, "R11 addr4 from 1234");
    check8(ext, 8'h03, "R11 ext from 1234");
    // R12 armed flag cleared: second execute alone is inert
    xfer(8'h06, 0, 0, 0, 0);
    xfer(8'h81, 1, 8'h00, 0, 0);
    xfer(8'h99, 0, 0, 0, 0);
    expect_rd(8'h00, "R12 armed flag cleared");
    xfer(8'h85, 0, 0, 0, 1);
    // second pattern nv=0x0E0A
    xfer(8'h06, 0, 0, 0, 0);
    xfer(8'hB1, 2, 8'h0A, 8'h0E, 0);
    xfer(8'h66, 0, 0, 0, 0);
    xfer(8'h99, 0, 0, 0, 0);
    expect_rd(8'h03, "R9 vol from 0E0A");
    xfer(8'h85, 0, 0, 0, 1);
    expect_rd(8'hDF, "R10 evol from 0E0A");
    xfer(8'h65, 0, 0, 0, 1);
    check8({7'd0, addr4}, 8'h01, "R11 addr4 from 0E0A");
    check8(ext, 8'h00, "R11 ext from 0E0A");
    // R13 / R8 opcode only first byte; unknown opcode
    expect_rd(8'hFF, "R13 second byte not opcode");
    xfer(8'h00, 1, 8'h85, 0, 1);
    expect_rd(8'hFF, "R8 unknown opcode");
    xfer(8'h9F, 0, 0, 0, 1);
    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL missing read bytes actual=0 expected=%0d", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule